// File: doc/BRIEF.md
# Acquisition Trigger Arming Controller

This block decides when a multi-channel acquisition starts and when the circular capture buffers are frozen. Three trigger sources feed it: a software request bit, a trigger cascaded from a neighbouring unit, and a hardware trigger input. A separate hardware freeze request and a software freeze bit feed the freeze path. Plain control levels set the cascade mask, the hardware freeze mask and automatic re-arming. Further control bits act only on their rising edge: the software trigger, the arm request, the status clear and the software freeze.

The hardware source has its own arm state. A rising edge of the arm bit arms it. A hardware trigger edge is accepted only while armed, and accepting it disarms the source. With automatic re-arm on, the source arms itself again one cycle later. With automatic re-arm off, it stays disarmed until the next arm edge. Any accepted trigger produces a single-cycle combined pulse and advances a trigger counter. Each source, the combined trigger and the freeze path keep a sticky status flag that only a rising edge of the clear bit resets.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level and is sampled on every rising clock edge.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: While rst_n is low and after its release, before any stimulus, both pulses, all six status outputs and trig_count_o are 0, and the hardware source is disarmed.
- R2: A rising edge of ctl_sw_trig makes trig_pulse_o high for exactly the cycle after the sampling edge. Holding the bit high produces no further pulse.
- R3: A rising edge of cascade_trig_i triggers only while ctl_cascade_en is 1. With the mask at 0 it produces no pulse and sets no status.
- R4: A rising edge of hw_trig_i triggers only while sts_armed_o is 1. A rising edge of ctl_arm sets sts_armed_o.
- R5: An accepted hardware trigger clears sts_armed_o. With ctl_auto_rearm at 0, later hardware edges are ignored until the next rising edge of ctl_arm.
- R6: With ctl_auto_rearm at 1, sts_armed_o is low for exactly one cycle after an accepted hardware trigger and then returns high.
- R7: The sticky flags sts_sw_o, sts_cascade_o, sts_hw_o, sts_combined_o and sts_freeze_o set on their event and hold until a rising edge of ctl_clear. An event in the same cycle as the clear edge leaves its flag set. The clear does not change sts_armed_o.
- R8: A rising edge of ctl_sw_freeze, or a rising edge of hw_freeze_i while ctl_hwfrz_en is 1, makes freeze_pulse_o high for one cycle and sets sts_freeze_o. A hardware freeze edge with the mask at 0 has no effect.
- R9: trig_count_o advances by one for every trig_pulse_o cycle. It wraps from its maximum to 0 and is reset only by rst_n. Its width is the CNT_W parameter, default 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sw_trig | input | 1 | Software trigger, acts on rising edge |
| ctl_cascade_en | input | 1 | Cascade trigger mask level |
| ctl_auto_rearm | input | 1 | Automatic hardware re-arm level |
| ctl_arm | input | 1 | Hardware arm request, acts on rising edge |
| ctl_clear | input | 1 | Sticky status clear, acts on rising edge |
| ctl_sw_freeze | input | 1 | Software freeze, acts on rising edge |
| ctl_hwfrz_en | input | 1 | Hardware freeze mask level |
| cascade_trig_i | input | 1 | Cascaded trigger, acts on rising edge |
| hw_trig_i | input | 1 | Hardware trigger, acts on rising edge |
| hw_freeze_i | input | 1 | Hardware freeze request, acts on rising edge |
| trig_pulse_o | output | 1 | Single-cycle combined trigger |
| freeze_pulse_o | output | 1 | Single-cycle buffer freeze |
| sts_sw_o | output | 1 | Sticky software trigger seen |
| sts_cascade_o | output | 1 | Sticky cascade trigger seen |
| sts_hw_o | output | 1 | Sticky hardware trigger accepted |
| sts_armed_o | output | 1 | Hardware source armed |
| sts_combined_o | output | 1 | Sticky combined trigger seen |
| sts_freeze_o | output | 1 | Sticky freeze seen |
| trig_count_o | output | CNT_W | Count of accepted triggers |

## Verification
The pulses, the sticky flags, the armed state and the counter all take their new values at the first rising edge that samples a stimulus, so each is due one cycle after the input is driven. The exception is automatic re-arm, which restores sts_armed_o one edge later still. The driver applies inputs on the falling edge and queues the expected state for the following rising edge. The monitor samples 2 ns after each rising edge and compares against the oldest queued item, so every comparison lines up with exactly one sampling edge. The bench overrides CNT_W to 4 so that the counter wrap can be reached.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  // bit positions of the edge-detected control and input bundle
  localparam int EDGE_W  = 7;
  localparam int E_SW    = 0;
  localparam int E_CASC  = 1;
  localparam int E_HW    = 2;
  localparam int E_ARM   = 3;
  localparam int E_CLR   = 4;
  localparam int E_SWFRZ = 5;
  localparam int E_HWFRZ = 6;

  // sticky status flag positions
  localparam int NUM_FLAGS = 5;
  localparam int F_SW      = 0;
  localparam int F_CASC    = 1;
  localparam int F_HW      = 2;
  localparam int F_COMB    = 3;
  localparam int F_FRZ     = 4;
endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/hw_arm_ctrl.sv
module hw_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_rise,
  input  logic auto_rearm,
  input  logic hw_rise,
  output logic hw_fire,
  output logic armed
);
  logic rearm_q;

  assign hw_fire = hw_rise & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      rearm_q <= hw_fire & auto_rearm;
      if (arm_rise || rearm_q) armed <= 1'b1;
      else if (hw_fire)        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_sw_trig,
  input  logic             ctl_cascade_en,
  input  logic             ctl_auto_rearm,
  input  logic             ctl_arm,
  input  logic             ctl_clear,
  input  logic             ctl_sw_freeze,
  input  logic             ctl_hwfrz_en,
  input  logic             cascade_trig_i,
  input  logic             hw_trig_i,
  input  logic             hw_freeze_i,
  output logic             trig_pulse_o,
  output logic             freeze_pulse_o,
  output logic             sts_sw_o,
  output logic             sts_cascade_o,
  output logic             sts_hw_o,
  output logic             sts_armed_o,
  output logic             sts_combined_o,
  output logic             sts_freeze_o,
  output logic [CNT_W-1:0] trig_count_o
);
  logic [EDGE_W-1:0]    raw_in, rise;
  logic [NUM_FLAGS-1:0] flag_set, flags;
  logic                 hw_fire, armed, clr_rise, arm_rise;
  logic                 trig_evt, frz_evt;

  always_comb begin
    raw_in          = '0;
    raw_in[E_SW]    = ctl_sw_trig;
    raw_in[E_CASC]  = cascade_trig_i;
    raw_in[E_HW]    = hw_trig_i;
    raw_in[E_ARM]   = ctl_arm;
    raw_in[E_CLR]   = ctl_clear;
    raw_in[E_SWFRZ] = ctl_sw_freeze;
    raw_in[E_HWFRZ] = hw_freeze_i;
  end

  edge_rise #(.W(EDGE_W)) u_edges (
    .clk (clk), .rst_n (rst_n), .din (raw_in), .rise (rise)
  );

  assign arm_rise = rise[E_ARM];
  assign clr_rise = rise[E_CLR];

  hw_arm_ctrl u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_rise   (arm_rise),
    .auto_rearm (ctl_auto_rearm),
    .hw_rise    (rise[E_HW]),
    .hw_fire    (hw_fire),
    .armed      (armed)
  );

  assign trig_evt = rise[E_SW] | (ctl_cascade_en & rise[E_CASC]) | hw_fire;
  assign frz_evt  = rise[E_SWFRZ] | (ctl_hwfrz_en & rise[E_HWFRZ]);

  always_comb begin
    flag_set         = '0;
    flag_set[F_SW]   = rise[E_SW];
    flag_set[F_CASC] = ctl_cascade_en & rise[E_CASC];
    flag_set[F_HW]   = hw_fire;
    flag_set[F_COMB] = trig_evt;
    flag_set[F_FRZ]  = frz_evt;
  end

  sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk (clk), .rst_n (rst_n), .set (flag_set), .clr (clr_rise), .flags (flags)
  );

  wrap_counter #(.W(CNT_W)) u_cnt (
    .clk (clk), .rst_n (rst_n), .inc (trig_evt), .count (trig_count_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_pulse_o   <= 1'b0;
      freeze_pulse_o <= 1'b0;
    end else begin
      trig_pulse_o   <= trig_evt;
      freeze_pulse_o <= frz_evt;
    end
  end

  assign sts_sw_o       = flags[F_SW];
  assign sts_cascade_o  = flags[F_CASC];
  assign sts_hw_o       = flags[F_HW];
  assign sts_combined_o = flags[F_COMB];
  assign sts_freeze_o   = flags[F_FRZ];
  assign sts_armed_o    = armed;
endmodule

// File: rtl/acq_trigger_ctrl_chk.sv
module acq_trigger_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_pulse_o,
  input logic             freeze_pulse_o,
  input logic             sts_armed_o,
  input logic             sts_combined_o,
  input logic             sts_freeze_o,
  input logic [CNT_W-1:0] trig_count_o,
  input logic             ctl_auto_rearm,
  input logic             hw_fire,
  input logic             arm_rise,
  input logic             clr_rise
);
  a_r2_pulse_marks_combined: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse_o |-> sts_combined_o);

  a_r8_freeze_marks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_pulse_o |-> sts_freeze_o);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse_o |-> trig_count_o == CNT_W'($past(trig_count_o) + 1'b1));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_pulse_o |-> $stable(trig_count_o));

  a_r5_disarm_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fire && !arm_rise) |=> !sts_armed_o);

  a_r6_auto_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fire && ctl_auto_rearm) |=> ##1 sts_armed_o);

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_combined_o && !clr_rise) |=> sts_combined_o);
endmodule

bind acq_trigger_ctrl acq_trigger_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trig_pulse_o   (trig_pulse_o),
  .freeze_pulse_o (freeze_pulse_o),
  .sts_armed_o    (sts_armed_o),
  .sts_combined_o (sts_combined_o),
  .sts_freeze_o   (sts_freeze_o),
  .trig_count_o   (trig_count_o),
  .ctl_auto_rearm (ctl_auto_rearm),
  .hw_fire        (hw_fire),
  .arm_rise       (arm_rise),
  .clr_rise       (clr_rise)
);

// File: tb/acq_trigger_ctrl_test.sv
module acq_trigger_ctrl_test;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 0, casc_en = 0, auto_ra = 0, arm = 0, clr = 0, swf = 0, hf_en = 0;
  logic casc = 0, hw = 0, hf = 0;
  logic pulse, frz, s_sw, s_casc, s_hw, s_armed, s_comb, s_frz;
  logic [CW-1:0] cnt;

  always #4 clk = ~clk;

  acq_trigger_ctrl #(.CNT_W(CW)) uut (
    .clk (clk), .rst_n (rst_n),
    .ctl_sw_trig (sw), .ctl_cascade_en (casc_en), .ctl_auto_rearm (auto_ra),
    .ctl_arm (arm), .ctl_clear (clr), .ctl_sw_freeze (swf), .ctl_hwfrz_en (hf_en),
    .cascade_trig_i (casc), .hw_trig_i (hw), .hw_freeze_i (hf),
    .trig_pulse_o (pulse), .freeze_pulse_o (frz),
    .sts_sw_o (s_sw), .sts_cascade_o (s_casc), .sts_hw_o (s_hw),
    .sts_armed_o (s_armed), .sts_combined_o (s_comb), .sts_freeze_o (s_frz),
    .trig_count_o (cnt)
  );

  typedef struct packed {
    logic          pulse;
    logic          frz;
    logic [4:0]    flags;   // 0 sw, 1 cascade, 2 hw, 3 combined, 4 freeze
    logic          armed;
    logic [CW-1:0] cnt;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0;
  logic done = 0;

  // bench model state, built from the requirements
  logic p_sw = 0, p_casc = 0, p_hw = 0, p_arm = 0, p_clr = 0, p_swf = 0, p_hf = 0;
  logic m_armed = 0, m_rearm = 0;
  logic [4:0] m_flags = '0;
  logic [CW-1:0] m_cnt = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(logic i_sw, logic i_casc, logic i_arm, logic i_hw,
                      logic i_clr, logic i_swf, logic i_hf);
    logic r_sw, r_casc, r_hw, r_arm, r_clr, r_swf, r_hf, fire, trig, fz;
    exp_t e;
    @(negedge clk);
    sw = i_sw; casc = i_casc; arm = i_arm; hw = i_hw; clr = i_clr; swf = i_swf; hf = i_hf;
    r_sw = i_sw & ~p_sw;   r_casc = i_casc & ~p_casc; r_hw = i_hw & ~p_hw;
    r_arm = i_arm & ~p_arm; r_clr = i_clr & ~p_clr;   r_swf = i_swf & ~p_swf;
    r_hf = i_hf & ~p_hf;
    p_sw = i_sw; p_casc = i_casc; p_hw = i_hw; p_arm = i_arm; p_clr = i_clr;
    p_swf = i_swf; p_hf = i_hf;
    fire = r_hw & m_armed;                                   // R4
    trig = r_sw | (casc_en & r_casc) | fire;                 // R2 R3
    fz   = r_swf | (hf_en & r_hf);                           // R8
    if (r_arm || m_rearm) m_armed = 1'b1;                    // R4 R6
    else if (fire)        m_armed = 1'b0;                    // R5
    m_rearm = fire & auto_ra;
    m_flags = (m_flags & {5{~r_clr}}) |
              {fz, trig, fire, casc_en & r_casc, r_sw};      // R7
    if (trig) m_cnt = m_cnt + 1'b1;                          // R9
    e.pulse = trig; e.frz = fz; e.flags = m_flags; e.armed = m_armed; e.cnt = m_cnt;
    exp_q.push_back(e);
  endtask

  task automatic set_levels(logic ce, logic ar, logic he);
    @(negedge clk);
    casc_en = ce; auto_ra = ar; hf_en = he;
  endtask

  // monitor: compares each sampling edge with the oldest queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check("R2 trig_pulse_o", pulse, e.pulse);
        check("R8 freeze_pulse_o", frz, e.frz);
        check("R7 sts_sw_o", s_sw, e.flags[0]);
        check("R3 sts_cascade_o", s_casc, e.flags[1]);
        check("R4 sts_hw_o", s_hw, e.flags[2]);
        check("R7 sts_combined_o", s_comb, e.flags[3]);
        check("R8 sts_freeze_o", s_frz, e.flags[4]);
        check("R5 sts_armed_o", s_armed, e.armed);
        check("R9 trig_count_o", cnt, e.cnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: state while in reset
    check("R1 reset pulses", {pulse, frz}, 0);
    check("R1 reset flags", {s_sw, s_casc, s_hw, s_armed, s_comb, s_frz}, 0);
    check("R1 reset count", cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 after release", {pulse, frz, s_sw, s_casc, s_hw, s_armed, s_comb, s_frz}, 0);
    check("R1 count after release", cnt, 0);

    // R2: software trigger, held high acts once
    step(0,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    // R7: clear edge resets sticky flags, held clear acts once
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0);

    // R3: cascade masked, then enabled
    step(0,1,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    set_levels(1,0,0);
    step(0,1,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    set_levels(0,0,0);

    // R4: hardware edge ignored while disarmed, then arm and fire
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0);
    step(0,0,1,1,0,0,0);
    step(0,0,0,0,0,0,0);
    // R5: no auto re-arm, next hardware edge ignored until a new arm edge
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0);
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);

    // R6: automatic re-arm
    set_levels(0,1,0);
    step(0,0,1,0,0,0,0);
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,1,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    set_levels(0,0,0);

    // R7: event and clear in the same cycle, armed state unaffected by clear
    step(1,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0);

    // R8: software freeze, masked and enabled hardware freeze
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,1);
    step(0,0,0,0,0,0,0);
    set_levels(0,0,1);
    step(0,0,0,0,0,0,1);
    step(0,0,0,0,0,0,0);

    // R9: counter wraps past its maximum
    for (int i = 0; i < 20; i++) begin
      step(1,0,0,0,0,0,0);
      step(0,0,0,0,0,0,0);
    end
    set_levels(1,0,0);
    step(1,1,0,0,0,0,0);
    step(0,0,0,0,0,0,0);

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule